// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codeword Decoder

This block takes a codeword built with an extended Hamming code and returns its K information bits. If one bit of the codeword was flipped, it repairs that bit, and this includes the overall parity bit. If two bits were flipped, it reports the error but does not try to repair it. The block computes an m-bit syndrome, with m the smallest value that satisfies 2^m >= m+K+1. It also computes one overall parity check across the whole word. The syndrome is driven on an output port, together with three flags: single error, double error, and "the repaired bit was an information bit".

Each non-parity bit of the codeword has a Hamming position numbered from 1 to K+m. The check bits sit at the power-of-two positions. The information bits fill the remaining positions in ascending order, with information bit 0 at the lowest such position. The overall parity bit makes the XOR of all K+m+1 bits equal to zero. The parameter `P0_AT_LSB` sets where that bit is stored:
- With `P0_AT_LSB=0` it is the MSB, and Hamming position p is stored at bit p-1.
- With `P0_AT_LSB=1` it is bit 0, and Hamming position p is stored at bit p.

The parameter `LATENCY` sets how many register stages the block has:
- 0: fully combinational.
- 1: the outputs are registered.
- 2: both the input word and the outputs are registered.

The registers use an asynchronous active-low reset and a clock enable.

Top module: `secded_decoder`

## Requirements
- R1: With an error-free codeword, the data output equals the encoded information, the syndrome is zero, and the single-error, double-error and repaired-data flags are all low.
- R2: With exactly one flipped bit at Hamming position p (1..K+m), the data output equals the original information, the syndrome equals p, the single-error flag is 1 and the double-error flag is 0.
- R3: With only the overall parity bit flipped, the data output equals the original information, the syndrome is zero, the single-error flag is 1 and the double-error flag is 0.
- R4: With two distinct flipped bits, the single-error flag is 0, the double-error flag is 1, and the syndrome equals the XOR of the two Hamming positions (the overall parity bit counts as position 0).
- R5: The repaired-data flag is 1 only when a single error sits at a non-power-of-two Hamming position (an information bit). It is 0 for errors in check bits or in the overall parity bit.
- R6: `P0_AT_LSB` selects whether the overall parity bit is codeword bit 0 or the MSB, shifting the other positions as described above.
- R7: With LATENCY 0 the outputs follow the input in the same cycle. With LATENCY 1 they follow after one enabled rising clock edge. With LATENCY 2 they follow after two.
- R8: While the clock enable is low, every registered output holds its value regardless of the input.
- R9: Asserting the reset low clears all registered outputs and flags to zero at once, without waiting for a clock edge.
- R10: The single-error and double-error flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the register stages (unused when LATENCY=0) |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Clock enable for all register stages |
| cw_i | input | K+m+1 | Codeword to decode |
| data_o | output | K | Corrected information bits |
| syn_o | output | m | Raw syndrome |
| sbe_o | output | 1 | Single-bit error seen (corrected) |
| dbe_o | output | 1 | Double-bit error seen (not corrected) |
| fix_o | output | 1 | The corrected bit lay in the information field |

## Verification
The hardest case to reach from the ports is a single flip of the overall parity bit. It gives a zero syndrome, which looks like a clean word, but the single-error flag must still be raised. Two other cases also need careful stimulus. Double flips involving that bit must give a syndrome equal to the other bit's position. The hold behaviour must be shown while the input changes under a low clock enable.

The bench carries its own encoder and works in Hamming positions, then maps them to each layout. It exercises every single flip position and every pair of positions for several data patterns. It does this on three instances at once, which together cover both parity-bit placements and all three latencies.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // smallest m with 2^m >= m + k + 1
   function automatic int chk_bits(input int k);
      int m;
      m = 1;
      while ((1 << m) < (m + k + 1)) m++;
      return m;
   endfunction

   // Hamming position (1-based) holding information bit j
   function automatic int info_pos(input int j);
      int cnt;
      cnt = 0;
      for (int p = 1; p < 65536; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == j) return p;
            cnt++;
         end
      end
      return 0;
   endfunction

   // codeword index of Hamming position p (p = 0 is the overall parity bit)
   function automatic int cw_index(input int p, input int n, input bit p0_lsb);
      if (p == 0) return p0_lsb ? 0 : n - 1;
      return p0_lsb ? p : p - 1;
   endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
   import secded_pkg::*;
#(
   parameter int K         = 8,
   parameter bit P0_AT_LSB = 1'b0,
   localparam int M        = chk_bits(K),
   localparam int N        = K + M + 1
) (
   input  logic [N-1:0] cw_i,
   output logic [M-1:0] syn_o,
   output logic         pfail_o
);

   always_comb begin
      syn_o = '0;
      for (int p = 1; p < N; p++) begin
         if (cw_i[cw_index(p, N, P0_AT_LSB)]) syn_o = syn_o ^ M'(p);
      end
   end

   assign pfail_o = ^cw_i;

endmodule

// File: rtl/secded_correct.sv
module secded_correct
   import secded_pkg::*;
#(
   parameter int K         = 8,
   parameter bit P0_AT_LSB = 1'b0,
   localparam int M        = chk_bits(K),
   localparam int N        = K + M + 1
) (
   input  logic [N-1:0] cw_i,
   input  logic [M-1:0] syn_i,
   input  logic         pfail_i,
   output logic [K-1:0] data_o,
   output logic         sbe_o,
   output logic         dbe_o,
   output logic         fix_o
);

   logic [N-1:0] fixed_cw;
   logic [K-1:0] info_hit;

   assign fixed_cw[cw_index(0, N, P0_AT_LSB)] = cw_i[cw_index(0, N, P0_AT_LSB)];

   for (genvar p = 1; p < N; p++) begin : g_flip
      localparam int IDX = cw_index(p, N, P0_AT_LSB);
      assign fixed_cw[IDX] = cw_i[IDX] ^ (pfail_i && (syn_i == M'(p)));
   end

   for (genvar j = 0; j < K; j++) begin : g_extract
      localparam int POS = info_pos(j);
      assign data_o[j]   = fixed_cw[cw_index(POS, N, P0_AT_LSB)];
      assign info_hit[j] = (syn_i == M'(POS));
   end

   assign sbe_o = pfail_i;
   assign dbe_o = !pfail_i && (syn_i != '0);
   assign fix_o = pfail_i && (|info_hit);

   always_comb begin
      // R10
      flags_excl_chk: assert (!(sbe_o && dbe_o));
      // R5
      fix_needs_sbe_chk: assert (!fix_o || (sbe_o && syn_i != '0));
   end

endmodule

// File: rtl/secded_stage.sv
module secded_stage #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         ce_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)  q_o <= '0;
      else if (ce_i) q_o <= d_i;
   end

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
   import secded_pkg::*;
#(
   parameter int K         = 8,
   parameter bit P0_AT_LSB = 1'b0,
   parameter int LATENCY   = 1,
   localparam int M        = chk_bits(K),
   localparam int N        = K + M + 1,
   localparam int OW       = K + M + 3
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         ce_i,
   input  logic [N-1:0] cw_i,
   output logic [K-1:0] data_o,
   output logic [M-1:0] syn_o,
   output logic         sbe_o,
   output logic         dbe_o,
   output logic         fix_o
);

   if (K < 1) begin : g_bad_k
      $error("secded_decoder: K must be at least 1");
   end
   if (LATENCY < 0 || LATENCY > 2) begin : g_bad_lat
      $error("secded_decoder: LATENCY must be 0, 1 or 2");
   end

   logic [N-1:0] cw_s;
   logic [M-1:0] syn_c;
   logic         pfail_c;
   logic [K-1:0] data_c;
   logic         sbe_c, dbe_c, fix_c;
   logic [OW-1:0] out_c, out_r;

   // optional input register
   if (LATENCY >= 2) begin : g_in_reg
      secded_stage #(.W(N)) in_stage_i (
         .clk_i(clk_i), .rst_n_i(rst_n_i), .ce_i(ce_i), .d_i(cw_i), .q_o(cw_s)
      );
   end else begin : g_in_wire
      assign cw_s = cw_i;
   end

   secded_syndrome #(.K(K), .P0_AT_LSB(P0_AT_LSB)) syn_i (
      .cw_i(cw_s), .syn_o(syn_c), .pfail_o(pfail_c)
   );

   secded_correct #(.K(K), .P0_AT_LSB(P0_AT_LSB)) cor_i (
      .cw_i(cw_s), .syn_i(syn_c), .pfail_i(pfail_c),
      .data_o(data_c), .sbe_o(sbe_c), .dbe_o(dbe_c), .fix_o(fix_c)
   );

   assign out_c = {data_c, syn_c, sbe_c, dbe_c, fix_c};

   // optional output register
   if (LATENCY >= 1) begin : g_out_reg
      secded_stage #(.W(OW)) out_stage_i (
         .clk_i(clk_i), .rst_n_i(rst_n_i), .ce_i(ce_i), .d_i(out_c), .q_o(out_r)
      );

      // R8
      hold_on_ce_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
         !ce_i |=> $stable(out_r));
   end else begin : g_out_wire
      assign out_r = out_c;
   end

   assign {data_o, syn_o, sbe_o, dbe_o, fix_o} = out_r;

   always_comb begin
      // R4
      dbe_needs_syn_chk: assert (!dbe_o || syn_o != '0);
      // R10
      port_flags_excl_chk: assert (!(sbe_o && dbe_o));
   end

endmodule

// File: tb/secded_decoder_tb_top.sv
`timescale 1ns/1ps
module secded_decoder_tb_top;
   import secded_pkg::*;

   localparam int K = 8;
   localparam int M = chk_bits(K);
   localparam int N = K + M + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b1;
   logic [N-1:0] cw_l0, cw_l1, cw_l2;

   logic [K-1:0] d0, d1, d2;
   logic [M-1:0] s0, s1, s2;
   logic sb0, sb1, sb2, db0, db1, db2, fx0, fx1, fx2;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   // LATENCY 1, parity bit at MSB
   secded_decoder #(.K(K), .P0_AT_LSB(1'b0), .LATENCY(1)) dut_i (
      .clk_i(clk), .rst_n_i(rst_n), .ce_i(ce), .cw_i(cw_l1),
      .data_o(d1), .syn_o(s1), .sbe_o(sb1), .dbe_o(db1), .fix_o(fx1));
   // LATENCY 0, parity bit at LSB
   secded_decoder #(.K(K), .P0_AT_LSB(1'b1), .LATENCY(0)) dut_l0_i (
      .clk_i(clk), .rst_n_i(rst_n), .ce_i(ce), .cw_i(cw_l0),
      .data_o(d0), .syn_o(s0), .sbe_o(sb0), .dbe_o(db0), .fix_o(fx0));
   // LATENCY 2, parity bit at MSB
   secded_decoder #(.K(K), .P0_AT_LSB(1'b0), .LATENCY(2)) dut_l2_i (
      .clk_i(clk), .rst_n_i(rst_n), .ce_i(ce), .cw_i(cw_l2),
      .data_o(d2), .syn_o(s2), .sbe_o(sb2), .dbe_o(db2), .fix_o(fx2));

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Hamming-position vector: bit 0 = overall parity, bit p = position p
   function automatic logic [N-1:0] encode_hv(input logic [K-1:0] d);
      logic [N-1:0] hv;
      int j;
      hv = '0;
      j = 0;
      for (int p = 1; p < N; p++)
         if ((p & (p - 1)) != 0) begin hv[p] = d[j]; j++; end
      for (int b = 0; b < M; b++) begin
         logic x;
         x = 1'b0;
         for (int p = 1; p < N; p++)
            if (((p >> b) & 1) != 0 && (p & (p - 1)) != 0) x ^= hv[p];
         hv[1 << b] = x;
      end
      hv[0] = ^hv[N-1:1];
      return hv;
   endfunction

   function automatic logic [N-1:0] lay_msb(input logic [N-1:0] hv);
      return {hv[0], hv[N-1:1]};
   endfunction

   // drive one word, check the three latencies at their own cycles
   task automatic apply(input string req, input logic [N-1:0] hv, input logic [K-1:0] d,
                        input logic chk_data, input logic [M-1:0] es,
                        input logic esb, input logic edb, input logic efx);
      @(negedge clk);
      cw_l0 = hv;
      cw_l1 = lay_msb(hv);
      cw_l2 = lay_msb(hv);
      #1;
      if (chk_data) chk({req, " R7 L0 data"}, 32'(d0), 32'(d));
      chk({req, " R6 L0 syn"}, 32'(s0), 32'(es));
      chk({req, " R10 L0 flags"}, {29'd0, sb0, db0, fx0}, {29'd0, esb, edb, efx});
      @(negedge clk);
      if (chk_data) chk({req, " R7 L1 data"}, 32'(d1), 32'(d));
      chk({req, " R7 L1 syn"}, 32'(s1), 32'(es));
      chk({req, " R7 L1 flags"}, {29'd0, sb1, db1, fx1}, {29'd0, esb, edb, efx});
      @(negedge clk);
      if (chk_data) chk({req, " R7 L2 data"}, 32'(d2), 32'(d));
      chk({req, " R7 L2 syn"}, 32'(s2), 32'(es));
      chk({req, " R7 L2 flags"}, {29'd0, sb2, db2, fx2}, {29'd0, esb, edb, efx});
   endtask

   task automatic test_reset();
      cw_l0 = '1; cw_l1 = '1; cw_l2 = '1;
      repeat (3) @(negedge clk);
      chk("R9 reset L1", {d1, s1, sb1, db1, fx1}, 32'd0);
      chk("R9 reset L2", {d2, s2, sb2, db2, fx2}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic test_clean();
      logic [K-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
      foreach (pats[i]) apply("R1 clean", encode_hv(pats[i]), pats[i], 1'b1, '0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_single();
      logic [K-1:0] pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
      foreach (pats[i])
         for (int p = 1; p < N; p++) begin
            logic isdata;
            isdata = ((p & (p - 1)) != 0);
            apply("R2 R5 single", encode_hv(pats[i]) ^ (N'(1) << p), pats[i], 1'b1,
                  M'(p), 1'b1, 1'b0, isdata);
         end
   endtask

   task automatic test_p0();
      logic [K-1:0] pats [3] = '{8'h00, 8'hC3, 8'h7E};
      foreach (pats[i])
         apply("R3 R6 parity-bit only", encode_hv(pats[i]) ^ N'(1), pats[i], 1'b1,
               '0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic test_double();
      logic [K-1:0] pats [2] = '{8'h96, 8'h0F};
      foreach (pats[i])
         for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
               apply("R4 double", encode_hv(pats[i]) ^ (N'(1) << a) ^ (N'(1) << b),
                     pats[i], 1'b0, M'(a ^ b), 1'b0, 1'b1, 1'b0);
   endtask

   task automatic test_ce_hold();
      apply("R8 setup", encode_hv(8'h12), 8'h12, 1'b1, '0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      ce = 1'b0;
      cw_l1 = lay_msb(encode_hv(8'hE7) ^ N'(2));
      cw_l2 = cw_l1;
      repeat (3) @(negedge clk);
      chk("R8 hold L1 data", 32'(d1), 32'h12);
      chk("R8 hold L1 flags", {29'd0, sb1, db1, fx1}, 32'd0);
      chk("R8 hold L2 data", 32'(d2), 32'h12);
      chk("R8 hold L2 flags", {29'd0, sb2, db2, fx2}, 32'd0);
      ce = 1'b1;
      @(negedge clk);
      chk("R7 R8 resume L1", {d1, s1, sb1, db1, fx1}, {8'hE7, 4'd1, 3'b100});
      @(negedge clk);
      chk("R7 R8 resume L2", {d2, s2, sb2, db2, fx2}, {8'hE7, 4'd1, 3'b100});
   endtask

   task automatic test_async_reset();
      apply("R9 setup", encode_hv(8'h44) ^ N'(8), 8'h44, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1);
      #0.5;
      rst_n = 1'b0;
      #0.5;
      chk("R9 async L1", {d1, s1, sb1, db1, fx1}, 32'd0);
      chk("R9 async L2", {d2, s2, sb2, db2, fx2}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      test_reset();
      test_clean();
      test_single();
      test_p0();
      test_double();
      test_ce_hold();
      test_async_reset();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule